// File: doc/BRIEF.md
# Two-Level Interrupt Routing Controller

This block collects interrupt events from two link controllers and steers them onto three general-purpose interrupt outputs. Each controller owns a leaf stage with two sticky capture registers. One is a small event register in which bit 3 records a hot reset. The other is a 32-bit vector register in which bit k records message vector k. Each capture register has its own enable register, where a 1 lets the source through. The gated leaf lines feed a per-controller middle stage. Its bit 0 takes the local-event line and its bit 1 takes the vector line.

Each middle stage has a status register, a write-one-to-enable register, a write-one-to-disable register and a read-only mask. The middle-stage outputs feed one top stage per output pin, built the same way. In the top stage, bit 1 carries controller 0 and bit 2 carries controller 1. Every output pin selects from the same source list, so one pin can route one source or several.

Every output line is a registered OR of its status bits that are not masked, so a raw event reaches a pin six clock edges after it arrives. A single-cycle register port programs all stages. Reads return data in the same cycle.

Top module: `irq_route`

## Requirements
- R1: The three output pins are independent. Each has its own top-stage register set. Every top-stage status register receives the same sources: bit 1 is controller 0 and bit 2 is controller 1. Pin p is at address 16+4p, with status at +0, enable at +1, disable at +2 and mask at +3.
- R2: Writing 1 to an enable-register bit clears that mask bit. Writing 1 to a disable-register bit sets it. Writing 0 bits changes nothing. The enable and disable registers read as 0.
- R3: Mask registers are read-only, and a write to a mask address leaves its value unchanged.
- R4: Controller c uses the following leaf registers: event capture at 8c+0, event enable at 8c+1, vector capture at 8c+2 and vector enable at 8c+3. An event input bit sets the matching capture bit (bit 3 is hot reset). The bit stays set until 1 is written to it. The middle-stage bit 0 is fed by the OR of capture AND enable. Writing 0 to the enable register blocks the source.
- R5: In the 32-bit vector capture register, bit k records vector k. The vector enable register passes vector k when its bit k is 1, and the gated OR feeds middle-stage bit 1. A vector that is not enabled is still recorded but does not reach the pin.
- R6: A status bit is set by its incoming line whether or not it is masked. A masked bit holds its status but does not drive the output. Unmasking a pending bit drives the output again.
- R7: When an event and a write-one-to-clear hit the same capture bit in the same cycle, the bit stays set.
- R8: Clearing a higher-stage status bit while the lower stage still signals causes that bit to set again. Clearing from leaf to middle to top drops the pin.
- R9: After reset, every mask bit is 1, every leaf enable is 0, every status and capture bit is 0, and all pins are low.
- R10: An event sampled at clock edge E1 raises its routed pin at edge E6, and not earlier.
- R11: The middle stage of controller c is at 8c: status at +4, enable at +5, disable at +6 and mask at +7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| evt_i | input | 16 | Event inputs, 8 per controller (controller c at [8c+7:8c]) |
| vec_i | input | 64 | Vector inputs, 32 per controller |
| irq_o | output | 3 | Interrupt output pins |

## Verification
On every cycle, the assertions check four things. Enable and disable writes move the mask in the right direction. A fully masked stage or a closed leaf enable keeps its output low. Status bits stay set until written. A set that coincides with a clear is not lost. Only the bench scenarios can show the rest: the end-to-end six-edge latency, the routing of each controller to the correct bit and pin, the effect of the clearing order, and the read-only mask seen through the register port.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 32;
  localparam int MID_W       = 2;
  localparam int CTRL_STRIDE = 8;
  localparam int PIN_BASE    = 16;
  localparam int PIN_STRIDE  = 4;

  // per-controller offsets
  localparam int OFF_EVT_CAP = 0;
  localparam int OFF_EVT_EN  = 1;
  localparam int OFF_VEC_CAP = 2;
  localparam int OFF_VEC_EN  = 3;
  localparam int OFF_MID_ST  = 4;
  localparam int OFF_MID_ENA = 5;
  localparam int OFF_MID_DIS = 6;
  localparam int OFF_MID_MSK = 7;
  // per-pin offsets
  localparam int OFF_TOP_ST  = 0;
  localparam int OFF_TOP_ENA = 1;
  localparam int OFF_TOP_DIS = 2;
  localparam int OFF_TOP_MSK = 3;

  function automatic logic [ADDR_W-1:0] ctrl_addr(input int c, input int off);
    return ADDR_W'(c * CTRL_STRIDE + off);
  endfunction

  function automatic logic [ADDR_W-1:0] pin_addr(input int p, input int off);
    return ADDR_W'(PIN_BASE + p * PIN_STRIDE + off);
  endfunction
endpackage

// File: rtl/irq_leaf_reg.sv
module irq_leaf_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] en_o,
  output logic         line_o
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o  <= '0;
      en_o   <= '0;
      line_o <= 1'b0;
    end else begin
      cap_o  <= (cap_o & ~clr_mask) | set_i;  // set wins
      if (en_we_i) en_o <= wdata_i;
      line_o <= |(cap_o & en_o);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((cap_o & $past(set_i)) == $past(set_i))); // R7

  AST_CLOSED_LEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_o) == '0) |-> !line_o); // R4
endmodule

// File: rtl/irq_stage.sv
module irq_stage #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         st_clr_we_i,
  input  logic         ena_we_i,
  input  logic         dis_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         line_o
);
  logic [W-1:0] clr_bits, ena_bits, dis_bits;
  assign clr_bits = st_clr_we_i ? wdata_i : '0;
  assign ena_bits = ena_we_i    ? wdata_i : '0;
  assign dis_bits = dis_we_i    ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      mask_o   <= '1;
      line_o   <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_bits) | src_i;
      mask_o   <= (mask_o & ~ena_bits) | dis_bits;
      line_o   <= |(status_o & ~mask_o);
    end
  end

  AST_DIS_SETS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_we_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_ENA_CLEARS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ena_we_i |=> ((mask_o & $past(wdata_i)) == '0)); // R2

  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(&mask_o) |-> !line_o); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R6
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int N_CTRL = 2,
  parameter int N_PIN  = 3,
  parameter int EVT_W  = 8,
  parameter int VEC_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [N_CTRL*EVT_W-1:0]   evt_i,
  input  logic [N_CTRL*VEC_W-1:0]   vec_i,
  output logic [N_PIN-1:0]          irq_o
);
  localparam int TOP_W = N_CTRL + 1;  // bit 0 reserved, bit c+1 = controller c

  logic [EVT_W-1:0] evt_cap [N_CTRL];
  logic [EVT_W-1:0] evt_en  [N_CTRL];
  logic [VEC_W-1:0] vec_cap [N_CTRL];
  logic [VEC_W-1:0] vec_en  [N_CTRL];
  logic [MID_W-1:0] mid_st  [N_CTRL];
  logic [MID_W-1:0] mid_msk [N_CTRL];
  logic [N_CTRL-1:0] mid_line;
  logic [TOP_W-1:0] top_st  [N_PIN];
  logic [TOP_W-1:0] top_msk [N_PIN];
  logic [TOP_W-1:0] top_src;

  function automatic logic wr_hit(input logic [ADDR_W-1:0] a);
    return we_i && (addr_i == a);
  endfunction

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    logic evt_line, vec_line;

    irq_leaf_reg #(.W(EVT_W)) u_evt (
      .clk_i, .rst_ni,
      .set_i   (evt_i[c*EVT_W +: EVT_W]),
      .clr_we_i(wr_hit(ctrl_addr(c, OFF_EVT_CAP))),
      .en_we_i (wr_hit(ctrl_addr(c, OFF_EVT_EN))),
      .wdata_i (wdata_i[EVT_W-1:0]),
      .cap_o   (evt_cap[c]),
      .en_o    (evt_en[c]),
      .line_o  (evt_line)
    );

    irq_leaf_reg #(.W(VEC_W)) u_vec (
      .clk_i, .rst_ni,
      .set_i   (vec_i[c*VEC_W +: VEC_W]),
      .clr_we_i(wr_hit(ctrl_addr(c, OFF_VEC_CAP))),
      .en_we_i (wr_hit(ctrl_addr(c, OFF_VEC_EN))),
      .wdata_i (wdata_i[VEC_W-1:0]),
      .cap_o   (vec_cap[c]),
      .en_o    (vec_en[c]),
      .line_o  (vec_line)
    );

    irq_stage #(.W(MID_W)) u_mid (
      .clk_i, .rst_ni,
      .src_i      ({vec_line, evt_line}),
      .st_clr_we_i(wr_hit(ctrl_addr(c, OFF_MID_ST))),
      .ena_we_i   (wr_hit(ctrl_addr(c, OFF_MID_ENA))),
      .dis_we_i   (wr_hit(ctrl_addr(c, OFF_MID_DIS))),
      .wdata_i    (wdata_i[MID_W-1:0]),
      .status_o   (mid_st[c]),
      .mask_o     (mid_msk[c]),
      .line_o     (mid_line[c])
    );
  end

  assign top_src = {mid_line, 1'b0};

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    irq_stage #(.W(TOP_W)) u_top (
      .clk_i, .rst_ni,
      .src_i      (top_src),
      .st_clr_we_i(wr_hit(pin_addr(p, OFF_TOP_ST))),
      .ena_we_i   (wr_hit(pin_addr(p, OFF_TOP_ENA))),
      .dis_we_i   (wr_hit(pin_addr(p, OFF_TOP_DIS))),
      .wdata_i    (wdata_i[TOP_W-1:0]),
      .status_o   (top_st[p]),
      .mask_o     (top_msk[p]),
      .line_o     (irq_o[p])
    );
  end

  // read mux; enable/disable addresses fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CTRL; c++) begin
      if (addr_i == ctrl_addr(c, OFF_EVT_CAP)) rdata_o = DATA_W'(evt_cap[c]);
      if (addr_i == ctrl_addr(c, OFF_EVT_EN))  rdata_o = DATA_W'(evt_en[c]);
      if (addr_i == ctrl_addr(c, OFF_VEC_CAP)) rdata_o = DATA_W'(vec_cap[c]);
      if (addr_i == ctrl_addr(c, OFF_VEC_EN))  rdata_o = DATA_W'(vec_en[c]);
      if (addr_i == ctrl_addr(c, OFF_MID_ST))  rdata_o = DATA_W'(mid_st[c]);
      if (addr_i == ctrl_addr(c, OFF_MID_MSK)) rdata_o = DATA_W'(mid_msk[c]);
    end
    for (int p = 0; p < N_PIN; p++) begin
      if (addr_i == pin_addr(p, OFF_TOP_ST))  rdata_o = DATA_W'(top_st[p]);
      if (addr_i == pin_addr(p, OFF_TOP_MSK)) rdata_o = DATA_W'(top_msk[p]);
    end
  end

  AST_RESERVED_BIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_st[0][0]); // R1
endmodule

// File: tb/irq_route_tb.sv
module irq_route_tb;
  localparam int AW = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] evt_i = '0;
  logic [63:0] vec_i = '0;
  logic [2:0]  irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  irq_route u_dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [AW-1:0] ca(input int c, input int off);
    return AW'(c * 8 + off);
  endfunction
  function automatic logic [AW-1:0] pa(input int p, input int off);
    return AW'(16 + p * 4 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R9", pa(0, 3), 32'h7);
    rd_chk("R9", pa(2, 3), 32'h7);
    rd_chk("R9", ca(1, 7), 32'h3);
    rd_chk("R9", ca(0, 1), 32'h0);
    rd_chk("R9", ca(1, 3), 32'h0);
    rd_chk("R9", pa(1, 0), 32'h0);
    chk("R9", 32'(irq_o), 32'h0);
  endtask

  task automatic t_mask_regs;
    wr(pa(0, 1), 32'h2);
    rd_chk("R2", pa(0, 3), 32'h5);
    rd_chk("R2", pa(0, 1), 32'h0);
    wr(pa(0, 3), 32'h0);
    rd_chk("R3", pa(0, 3), 32'h5);
    wr(pa(0, 1), 32'h0);
    rd_chk("R2", pa(0, 3), 32'h5);
    wr(pa(0, 2), 32'h2);
    rd_chk("R2", pa(0, 3), 32'h7);
    wr(ca(1, 5), 32'h2);
    rd_chk("R11", ca(1, 7), 32'h1);
    wr(ca(1, 6), 32'h2);
    rd_chk("R11", ca(1, 7), 32'h3);
  endtask

  task automatic t_hot_reset;
    wr(pa(0, 1), 32'h2);
    wr(ca(0, 5), 32'h1);
    wr(ca(0, 1), 32'h8);
    @(negedge clk_i);
    evt_i[3] = 1'b1;
    @(negedge clk_i);           // after E1
    evt_i[3] = 1'b0;
    cyc(4);                     // after E5
    chk("R10", 32'(irq_o[0]), 32'h0);
    cyc(1);                     // after E6
    chk("R10", 32'(irq_o[0]), 32'h1);
    chk("R1", 32'(irq_o[2:1]), 32'h0);
    rd_chk("R4", ca(0, 0), 32'h8);
    rd_chk("R11", ca(0, 4), 32'h1);
    rd_chk("R1", pa(0, 0), 32'h2);
    rd_chk("R6", pa(1, 0), 32'h2);
    // clear top first while lower still pending: re-sets
    wr(pa(0, 0), 32'h2);
    cyc(3);
    rd_chk("R8", pa(0, 0), 32'h2);
    // service in order
    wr(ca(0, 1), 32'h0);
    wr(ca(0, 0), 32'h8);
    rd_chk("R4", ca(0, 0), 32'h0);
    cyc(2);
    wr(ca(0, 4), 32'h1);
    cyc(2);
    wr(pa(0, 0), 32'h2);
    wr(pa(1, 0), 32'h2);
    wr(pa(2, 0), 32'h2);
    cyc(3);
    rd_chk("R8", pa(0, 0), 32'h0);
    chk("R8", 32'(irq_o), 32'h0);
  endtask

  task automatic t_vector;
    wr(pa(2, 1), 32'h4);
    wr(ca(1, 5), 32'h2);
    wr(ca(1, 3), 32'h1);
    @(negedge clk_i);
    vec_i[32 + 5] = 1'b1;
    @(negedge clk_i);
    vec_i[32 + 5] = 1'b0;
    cyc(8);
    chk("R5", 32'(irq_o[2]), 32'h0);
    rd_chk("R5", ca(1, 2), 32'h20);
    @(negedge clk_i);
    vec_i[32] = 1'b1;
    @(negedge clk_i);
    vec_i[32] = 1'b0;
    cyc(5);
    chk("R5", 32'(irq_o[2]), 32'h1);
    chk("R1", 32'(irq_o[1:0]), 32'h0);
    rd_chk("R1", pa(2, 0), 32'h4);
    wr(pa(2, 2), 32'h4);
    cyc(2);
    chk("R6", 32'(irq_o[2]), 32'h0);
    rd_chk("R6", pa(2, 0), 32'h4);
    wr(pa(2, 1), 32'h4);
    cyc(2);
    chk("R6", 32'(irq_o[2]), 32'h1);
    // clean up
    wr(ca(1, 3), 32'h0);
    wr(ca(1, 2), 32'hffff_ffff);
    cyc(2);
    wr(ca(1, 4), 32'h3);
    cyc(2);
    for (int p = 0; p < 3; p++) wr(pa(p, 0), 32'h7);
    cyc(3);
    chk("R8", 32'(irq_o), 32'h0);
  endtask

  task automatic t_set_wins;
    @(negedge clk_i);
    we_i = 1'b1; addr_i = ca(1, 0); wdata_i = 32'h8;
    evt_i[8 + 3] = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0; evt_i = '0;
    rd_chk("R7", ca(1, 0), 32'h8);
    wr(ca(1, 0), 32'h8);
    rd_chk("R4", ca(1, 0), 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_mask_regs();
    t_hot_reset();
    t_vector();
    t_set_wins();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule